// File: doc/BRIEF.md
# SDRAM Controller Configuration Registers

This block is the configuration register file of an SDRAM controller. Software reaches it through two addresses on a simple device-control bus. The first address holds a 32-bit internal offset and reads it back. The second address reads or writes whichever internal register that offset selects. Behind this window sit:

- two error status words, which are write-one-to-clear;
- an error address;
- a configuration word and a read-only status word;
- refresh, power-timer and timing words;
- one configuration word per memory bank;
- an ECC configuration word and an ECC error status word.

Each register applies its own write mask when it is written. A small state machine watches writes to the configuration word. When the controller-enable bit (bit 31) or the auxiliary mode bit (bit 30) changes, the machine updates the matching status bits. The ECC error status word drives a level interrupt. Each bank word is presented as an output, together with a per-bank "mapped" flag, for a separate address decoder. The timing word is also an output, for the command sequencer.

Enable state machine:
- States: `RUN_RESET` (never enabled since reset), `RUN_ACTIVE` and `RUN_STOPPED`.
- Transitions: ACTIVATE (`RUN_RESET` to `RUN_ACTIVE`), DEACTIVATE (`RUN_ACTIVE` to `RUN_STOPPED`) and REACTIVATE (`RUN_STOPPED` to `RUN_ACTIVE`). Each is taken on a configuration write that changes bit 31.

Auxiliary state machine:
- States: `AUX_CLEAR` and `AUX_SET`.
- Transitions: AUX_RISE and AUX_FALL, driven by bit 30 of configuration writes.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to bus address 0x010 stores all 32 bits as the internal offset, and a read of 0x010 returns it. Bus address 0x011 accesses the register at that offset. A read of any other bus address gives no response.
- R2: A read strobe on 0x010 or 0x011 produces `bus_rvalid_o` high for exactly one cycle on the next cycle, with the data. A write takes effect at the clock edge that samples the write strobe.
- R3: After reset these values apply: offset 0, configuration 0x00800000, refresh 0x05F00000, power timer 0x07C00000, timing 0x00854009, and every other register 0. After reset `ctl_enable_o`, `bank_map_en_o` and `ecc_irq_o` are low.
- R4: The error status words at offsets 0x00 and 0x08 clear each bit written as 1, and since nothing in the block sets them they read 0. The error address at offset 0x10 stores all 32 bits.
- R5: A configuration write (offset 0x20) keeps bits 31:21 and zeroes the rest.
- R6: When configuration bit 31 goes from 0 to 1, status bit 31 clears and `ctl_enable_o` rises. When it goes from 1 to 0, status bit 31 sets and `ctl_enable_o` falls. A write that leaves bit 31 unchanged changes neither. After reset status bit 31 is 0.
- R7: When configuration bit 30 goes from 0 to 1, status bit 30 sets. When it goes from 1 to 0, status bit 30 clears.
- R8: The status word at offset 0x24 ignores writes.
- R9: Write masks apply as follows:
  - refresh (0x30) uses 0x3FF80000;
  - timing (0x80) uses 0x018FC01F and is shown on `timing_o`;
  - ECC configuration (0x94) uses 0x00F00000;
  - power timer (0x34) keeps bits 31:27 and forces bits 26:22 to 1.
- R10: The bank word i sits at offset 0x40+4i and stores the written value masked with 0xFFDEE001. `bank_map_en_o[i]` is high when `ctl_enable_o` is high and bit 0 of bank word i is 1.
- R11: The ECC error status (0x98) stores the written value masked with 0xFFF0F000. `ecc_irq_o` rises when the stored value goes from zero to nonzero, and falls when it goes from nonzero to zero.
- R12: A read of offset 0x80, or of any offset with no register, returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| bus_rdata_o | output | 32 | Read data |
| ctl_enable_o | output | 1 | Controller enabled |
| bank_word_o | output | NB*32 | Stored bank words, bank 0 in the low bits |
| bank_map_en_o | output | NB | Per-bank mapping enable |
| timing_o | output | 32 | Stored timing word |
| ecc_irq_o | output | 1 | ECC error interrupt |

## Verification
The assertions check on every cycle that:
- read responses follow their strobes by one cycle;
- the enable output and the interrupt change only after a write of the right offset and value;
- the status word moves only after a configuration write;
- the forced power-timer bits and the timing mask always hold;
- no bank is mapped while the controller is disabled.

Only the bench's scenarios can show the rest:
- the per-register masks over whole patterns;
- the all-ones return of the timing and unused offsets, swept over the offset space;
- the exact status values after each rise and fall of the configuration bits.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

    // internal offsets (software-visible, decoded by the offset port)
    localparam logic [31:0] OFS_ERRST0  = 32'h0000_0000;
    localparam logic [31:0] OFS_ERRST1  = 32'h0000_0008;
    localparam logic [31:0] OFS_ERRADDR = 32'h0000_0010;
    localparam logic [31:0] OFS_CFG     = 32'h0000_0020;
    localparam logic [31:0] OFS_STAT    = 32'h0000_0024;
    localparam logic [31:0] OFS_REFRESH = 32'h0000_0030;
    localparam logic [31:0] OFS_PWRTMR  = 32'h0000_0034;
    localparam logic [31:0] OFS_BANK0   = 32'h0000_0040;
    localparam logic [31:0] OFS_TIMING  = 32'h0000_0080;
    localparam logic [31:0] OFS_ECCCFG  = 32'h0000_0094;
    localparam logic [31:0] OFS_ECCST   = 32'h0000_0098;

    // write masks
    localparam logic [31:0] CFG_MASK     = 32'hFFE0_0000;
    localparam logic [31:0] REFRESH_MASK = 32'h3FF8_0000;
    localparam logic [31:0] PWR_KEEP     = 32'hF800_0000;
    localparam logic [31:0] PWR_FORCE    = 32'h07C0_0000;
    localparam logic [31:0] TIMING_MASK  = 32'h018F_C01F;
    localparam logic [31:0] ECCCFG_MASK  = 32'h00F0_0000;
    localparam logic [31:0] ECCST_MASK   = 32'hFFF0_F000;
    localparam logic [31:0] BANK_MASK    = 32'hFFDE_E001;

    // reset values
    localparam logic [31:0] CFG_RST     = 32'h0080_0000;
    localparam logic [31:0] REFRESH_RST = 32'h05F0_0000;
    localparam logic [31:0] PWR_RST     = 32'h07C0_0000;
    localparam logic [31:0] TIMING_RST  = 32'h0085_4009;

    localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        SEL_ERRST0,
        SEL_ERRST1,
        SEL_ERRADDR,
        SEL_CFG,
        SEL_STAT,
        SEL_REFRESH,
        SEL_PWRTMR,
        SEL_BANK,
        SEL_TIMING,
        SEL_ECCCFG,
        SEL_ECCST,
        SEL_NONE
    } reg_sel_t;

    typedef enum logic [1:0] {
        RUN_RESET,
        RUN_ACTIVE,
        RUN_STOPPED
    } run_state_t;

    typedef enum logic {
        AUX_CLEAR,
        AUX_SET
    } aux_state_t;

endpackage

// File: rtl/memctl_cfg_decode.sv
module memctl_cfg_decode
    import memctl_cfg_pkg::*;
#(
    parameter int NB = 4,
    localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [31:0]       offset_i,
    output reg_sel_t          sel_o,
    output logic [BIDX_W-1:0] bank_idx_o
);

    localparam logic [31:0] BANK_SPAN = 32'(NB * 4);

    logic [31:0] rel;

    always_comb begin
        rel        = offset_i - OFS_BANK0;
        sel_o      = SEL_NONE;
        bank_idx_o = '0;
        case (offset_i)
            OFS_ERRST0:  sel_o = SEL_ERRST0;
            OFS_ERRST1:  sel_o = SEL_ERRST1;
            OFS_ERRADDR: sel_o = SEL_ERRADDR;
            OFS_CFG:     sel_o = SEL_CFG;
            OFS_STAT:    sel_o = SEL_STAT;
            OFS_REFRESH: sel_o = SEL_REFRESH;
            OFS_PWRTMR:  sel_o = SEL_PWRTMR;
            OFS_TIMING:  sel_o = SEL_TIMING;
            OFS_ECCCFG:  sel_o = SEL_ECCCFG;
            OFS_ECCST:   sel_o = SEL_ECCST;
            default:     sel_o = SEL_NONE;
        endcase
        if ((rel < BANK_SPAN) && (rel[1:0] == 2'b00)) begin
            sel_o      = SEL_BANK;
            bank_idx_o = rel[BIDX_W+1:2];
        end
    end

endmodule

// File: rtl/memctl_cfg_mode_fsm.sv
module memctl_cfg_mode_fsm
    import memctl_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_i,
    input  logic run_bit_i,
    input  logic aux_bit_i,
    output logic run_on_o,
    output logic run_stopped_o,
    output logic aux_flag_o
);

    run_state_t run_q, run_d;
    aux_state_t aux_q, aux_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_RESET;
            aux_q <= AUX_CLEAR;
        end else begin
            run_q <= run_d;
            aux_q <= aux_d;
        end
    end

    // next state
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_RESET:   if (cfg_wr_i && run_bit_i)  run_d = RUN_ACTIVE;   // ACTIVATE
            RUN_ACTIVE:  if (cfg_wr_i && !run_bit_i) run_d = RUN_STOPPED;  // DEACTIVATE
            RUN_STOPPED: if (cfg_wr_i && run_bit_i)  run_d = RUN_ACTIVE;   // REACTIVATE
            default:     run_d = RUN_RESET;
        endcase
        aux_d = aux_q;
        unique case (aux_q)
            AUX_CLEAR: if (cfg_wr_i && aux_bit_i)  aux_d = AUX_SET;    // AUX_RISE
            AUX_SET:   if (cfg_wr_i && !aux_bit_i) aux_d = AUX_CLEAR;  // AUX_FALL
            default:   aux_d = AUX_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        run_on_o      = (run_q == RUN_ACTIVE);
        run_stopped_o = (run_q == RUN_STOPPED);
        aux_flag_o    = (aux_q == AUX_SET);
    end

endmodule

// File: rtl/memctl_cfg_banks.sv
module memctl_cfg_banks
    import memctl_cfg_pkg::*;
#(
    parameter int NB = 4,
    localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BIDX_W-1:0] idx_i,
    input  logic [31:0]       wdata_i,
    input  logic              run_on_i,
    output logic [NB*32-1:0]  word_o,
    output logic [NB-1:0]     map_en_o
);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_i && (idx_i == BIDX_W'(g))) begin
                word_q <= wdata_i & BANK_MASK;
            end
        end

        assign word_o[g*32 +: 32] = word_q;
        assign map_en_o[g]        = run_on_i & word_q[0];
    end

endmodule

// File: rtl/memctl_cfg_ecc.sv
module memctl_cfg_ecc
    import memctl_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] status_o,
    output logic        irq_o
);

    logic [31:0] masked;
    logic [31:0] st_q;
    logic        irq_q;

    assign masked = wdata_i & ECCST_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            irq_q <= 1'b0;
        end else if (wr_i) begin
            st_q <= masked;
            if ((st_q == '0) && (masked != '0)) begin
                irq_q <= 1'b1;
            end else if ((st_q != '0) && (masked == '0)) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign status_o = st_q;
    assign irq_o    = irq_q;

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import memctl_cfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NB     = 4,
    parameter logic [ADDR_W-1:0] OFS_PORT  = ADDR_W'('h010),
    parameter logic [ADDR_W-1:0] DATA_PORT = ADDR_W'('h011)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_rvalid_o,
    output logic [31:0]       bus_rdata_o,
    output logic              ctl_enable_o,
    output logic [NB*32-1:0]  bank_word_o,
    output logic [NB-1:0]     bank_map_en_o,
    output logic [31:0]       timing_o,
    output logic              ecc_irq_o
);

    localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [31:0] offset_q;
    logic [31:0] errst_q [2];
    logic [31:0] erraddr_q;
    logic [31:0] cfg_q;
    logic [31:0] refresh_q;
    logic [31:0] pwrtmr_q;
    logic [31:0] timing_q;
    logic [31:0] ecccfg_q;
    logic [31:0] eccst;
    logic [31:0] stat_q;
    logic [31:0] rd_mux;
    logic [31:0] rdata_q;
    logic        rvalid_q;

    reg_sel_t          sel;
    logic [BIDX_W-1:0] bank_idx;

    logic ofs_wr, data_wr, rd_hit;
    logic run_on, run_stopped, aux_flag;

    assign ofs_wr  = bus_wr_i && (bus_addr_i == OFS_PORT);
    assign data_wr = bus_wr_i && (bus_addr_i == DATA_PORT);
    assign rd_hit  = bus_rd_i && ((bus_addr_i == OFS_PORT) || (bus_addr_i == DATA_PORT));

    memctl_cfg_decode #(.NB(NB)) decode_i (
        .offset_i   (offset_q),
        .sel_o      (sel),
        .bank_idx_o (bank_idx)
    );

    memctl_cfg_mode_fsm mode_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_i      (data_wr && (sel == SEL_CFG)),
        .run_bit_i     (bus_wdata_i[31]),
        .aux_bit_i     (bus_wdata_i[30]),
        .run_on_o      (run_on),
        .run_stopped_o (run_stopped),
        .aux_flag_o    (aux_flag)
    );

    memctl_cfg_banks #(.NB(NB)) banks_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (data_wr && (sel == SEL_BANK)),
        .idx_i    (bank_idx),
        .wdata_i  (bus_wdata_i),
        .run_on_i (run_on),
        .word_o   (bank_word_o),
        .map_en_o (bank_map_en_o)
    );

    memctl_cfg_ecc ecc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (data_wr && (sel == SEL_ECCST)),
        .wdata_i  (bus_wdata_i),
        .status_o (eccst),
        .irq_o    (ecc_irq_o)
    );

    assign stat_q = {run_stopped, aux_flag, 30'b0};

    // offset port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (ofs_wr) begin
            offset_q <= bus_wdata_i;
        end
    end

    // plain registers behind the data port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            errst_q[0] <= '0;
            errst_q[1] <= '0;
            erraddr_q  <= '0;
            cfg_q      <= CFG_RST;
            refresh_q  <= REFRESH_RST;
            pwrtmr_q   <= PWR_RST;
            timing_q   <= TIMING_RST;
            ecccfg_q   <= '0;
        end else if (data_wr) begin
            unique case (sel)
                SEL_ERRST0:  errst_q[0] <= errst_q[0] & ~bus_wdata_i;
                SEL_ERRST1:  errst_q[1] <= errst_q[1] & ~bus_wdata_i;
                SEL_ERRADDR: erraddr_q  <= bus_wdata_i;
                SEL_CFG:     cfg_q      <= bus_wdata_i & CFG_MASK;
                SEL_REFRESH: refresh_q  <= bus_wdata_i & REFRESH_MASK;
                SEL_PWRTMR:  pwrtmr_q   <= (bus_wdata_i & PWR_KEEP) | PWR_FORCE;
                SEL_TIMING:  timing_q   <= bus_wdata_i & TIMING_MASK;
                SEL_ECCCFG:  ecccfg_q   <= bus_wdata_i & ECCCFG_MASK;
                default:     ;
            endcase
        end
    end

    // read selection
    always_comb begin
        if (bus_addr_i == OFS_PORT) begin
            rd_mux = offset_q;
        end else begin
            unique case (sel)
                SEL_ERRST0:  rd_mux = errst_q[0];
                SEL_ERRST1:  rd_mux = errst_q[1];
                SEL_ERRADDR: rd_mux = erraddr_q;
                SEL_CFG:     rd_mux = cfg_q;
                SEL_STAT:    rd_mux = stat_q;
                SEL_REFRESH: rd_mux = refresh_q;
                SEL_PWRTMR:  rd_mux = pwrtmr_q;
                SEL_BANK:    rd_mux = bank_word_o[int'(bank_idx)*32 +: 32];
                SEL_ECCCFG:  rd_mux = ecccfg_q;
                SEL_ECCST:   rd_mux = eccst;
                default:     rd_mux = ALL_ONES;
            endcase
        end
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_hit;
            if (rd_hit) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rvalid_o = rvalid_q;
    assign bus_rdata_o  = rdata_q;
    assign ctl_enable_o = run_on;
    assign timing_o     = timing_q;

endmodule

// File: rtl/memctl_cfg_checker.sv
module memctl_cfg_checker
    import memctl_cfg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NB     = 4,
    parameter logic [ADDR_W-1:0] OFS_PORT  = ADDR_W'('h010),
    parameter logic [ADDR_W-1:0] DATA_PORT = ADDR_W'('h011)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [31:0]       bus_wdata_i,
    input logic              bus_rvalid_o,
    input logic              ctl_enable_o,
    input logic [NB-1:0]     bank_map_en_o,
    input logic [31:0]       timing_o,
    input logic              ecc_irq_o,
    input logic [31:0]       offset_q,
    input logic [31:0]       stat_q,
    input logic [31:0]       pwrtmr_q
);

    logic rd_hit, data_wr;
    assign rd_hit  = bus_rd_i && ((bus_addr_i == OFS_PORT) || (bus_addr_i == DATA_PORT));
    assign data_wr = bus_wr_i && (bus_addr_i == DATA_PORT);

    assert_rvalid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> $past(rd_hit));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> bus_rvalid_o);

    assert_enable_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_enable_o) |-> $past(data_wr && (offset_q == OFS_CFG) && bus_wdata_i[31]));

    assert_enable_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_enable_o) |-> $past(data_wr && (offset_q == OFS_CFG) && !bus_wdata_i[31]));

    assert_status_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(data_wr && (offset_q == OFS_CFG)) |-> $stable(stat_q));

    assert_pwr_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrtmr_q & ~PWR_KEEP) == PWR_FORCE);

    assert_timing_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_o & ~TIMING_MASK) == 32'h0);

    assert_map_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_map_en_o) |-> ctl_enable_o);

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecc_irq_o) |-> $past(data_wr && (offset_q == OFS_ECCST) && ((bus_wdata_i & ECCST_MASK) != 32'h0)));

    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ecc_irq_o) |-> $past(data_wr && (offset_q == OFS_ECCST) && ((bus_wdata_i & ECCST_MASK) == 32'h0)));

endmodule

bind memctl_cfg_regs memctl_cfg_checker #(
    .ADDR_W    (ADDR_W),
    .NB        (NB),
    .OFS_PORT  (OFS_PORT),
    .DATA_PORT (DATA_PORT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr_i    (bus_addr_i),
    .bus_rd_i      (bus_rd_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rvalid_o  (bus_rvalid_o),
    .ctl_enable_o  (ctl_enable_o),
    .bank_map_en_o (bank_map_en_o),
    .timing_o      (timing_o),
    .ecc_irq_o     (ecc_irq_o),
    .offset_q      (offset_q),
    .stat_q        (stat_q),
    .pwrtmr_q      (pwrtmr_q)
);

// File: tb/memctl_cfg_regs_tb.sv
`timescale 1ns/1ps
module memctl_cfg_regs_tb_top;

    localparam int ADDR_W = 10;
    localparam int NB     = 4;
    localparam logic [ADDR_W-1:0] P_OFS  = 10'h010;
    localparam logic [ADDR_W-1:0] P_DATA = 10'h011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr_i = '0;
    logic              bus_rd_i = 1'b0;
    logic              bus_wr_i = 1'b0;
    logic [31:0]       bus_wdata_i = '0;
    logic              bus_rvalid_o;
    logic [31:0]       bus_rdata_o;
    logic              ctl_enable_o;
    logic [NB*32-1:0]  bank_word_o;
    logic [NB-1:0]     bank_map_en_o;
    logic [31:0]       timing_o;
    logic              ecc_irq_o;

    always #2.5 clk = ~clk;

    memctl_cfg_regs #(.ADDR_W(ADDR_W), .NB(NB)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr_i    (bus_addr_i),
        .bus_rd_i      (bus_rd_i),
        .bus_wr_i      (bus_wr_i),
        .bus_wdata_i   (bus_wdata_i),
        .bus_rvalid_o  (bus_rvalid_o),
        .bus_rdata_o   (bus_rdata_o),
        .ctl_enable_o  (ctl_enable_o),
        .bank_word_o   (bank_word_o),
        .bank_map_en_o (bank_map_en_o),
        .timing_o      (timing_o),
        .ecc_irq_o     (ecc_irq_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // requirement model
    logic [31:0] m_off, m_bear, m_cfg, m_rtr, m_pmit, m_tr, m_ecccfg, m_eccst;
    logic [31:0] m_bank [NB];
    logic        m_s31, m_s30, m_en;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_off = 0; m_bear = 0; m_cfg = 32'h0080_0000; m_rtr = 32'h05F0_0000;
        m_pmit = 32'h07C0_0000; m_tr = 32'h0085_4009; m_ecccfg = 0; m_eccst = 0;
        for (int i = 0; i < NB; i++) m_bank[i] = 0;
        m_s31 = 0; m_s30 = 0; m_en = 0;
    endtask

    task automatic model_write(input logic [31:0] off, input logic [31:0] v);
        logic [31:0] n;
        if (off == 32'h10) m_bear = v;
        else if (off == 32'h20) begin
            n = v & 32'hFFE0_0000;
            if (!m_cfg[31] && n[31]) begin m_s31 = 0; m_en = 1; end
            else if (m_cfg[31] && !n[31]) begin m_s31 = 1; m_en = 0; end
            if (!m_cfg[30] && n[30]) m_s30 = 1;
            else if (m_cfg[30] && !n[30]) m_s30 = 0;
            m_cfg = n;
        end
        else if (off == 32'h30) m_rtr = v & 32'h3FF8_0000;
        else if (off == 32'h34) m_pmit = (v & 32'hF800_0000) | 32'h07C0_0000;
        else if (off >= 32'h40 && off < 32'h40 + NB*4 && off[1:0] == 0)
            m_bank[(off - 32'h40) >> 2] = v & 32'hFFDE_E001;
        else if (off == 32'h80) m_tr = v & 32'h018F_C01F;
        else if (off == 32'h94) m_ecccfg = v & 32'h00F0_0000;
        else if (off == 32'h98) m_eccst = v & 32'hFFF0_F000;
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] off);
        if (off == 32'h00 || off == 32'h08) return 32'h0;
        if (off == 32'h10) return m_bear;
        if (off == 32'h20) return m_cfg;
        if (off == 32'h24) return {m_s31, m_s30, 30'b0};
        if (off == 32'h30) return m_rtr;
        if (off == 32'h34) return m_pmit;
        if (off >= 32'h40 && off < 32'h40 + NB*4 && off[1:0] == 0) return m_bank[(off - 32'h40) >> 2];
        if (off == 32'h94) return m_ecccfg;
        if (off == 32'h98) return m_eccst;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_addr_i = a; bus_rd_i = 1'b1;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o; v = bus_rvalid_o;
    endtask

    task automatic reg_write(input logic [31:0] off, input logic [31:0] v);
        bus_write(P_OFS, off); m_off = off;
        bus_write(P_DATA, v);
        model_write(off, v);
    endtask

    task automatic reg_check(input logic [31:0] off, input string req);
        logic [31:0] d; logic v;
        bus_write(P_OFS, off); m_off = off;
        bus_read(P_DATA, d, v);
        chk(v && d == exp_read(off), req, d, exp_read(off));
    endtask

    task automatic out_check(input string req);
        logic [NB-1:0] em;
        for (int i = 0; i < NB; i++) em[i] = m_en & m_bank[i][0];
        chk(ctl_enable_o == m_en, {req, " R6 enable"}, 32'(ctl_enable_o), 32'(m_en));
        chk(ecc_irq_o == (m_eccst != 0), {req, " R11 irq"}, 32'(ecc_irq_o), 32'(m_eccst != 0));
        chk(timing_o == m_tr, {req, " R9 timing_o"}, timing_o, m_tr);
        chk(bank_map_en_o == em, {req, " R10 map"}, 32'(bank_map_en_o), 32'(em));
        for (int i = 0; i < NB; i++)
            chk(bank_word_o[i*32 +: 32] == m_bank[i], {req, " R10 word"}, bank_word_o[i*32 +: 32], m_bank[i]);
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 64; k++) reg_check(32'(k * 4), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic v;
        logic [31:0] pats [4];
        logic [31:0] defs [14];
        pats = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_0000};
        defs = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34,
                 32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98};
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R3 reset state
        chk(bus_rvalid_o == 0, "R3 rvalid after reset", 32'(bus_rvalid_o), 0);
        out_check("R3 reset outputs");
        bus_read(P_OFS, d, v);
        chk(v && d == 0, "R3 R1 offset reset", d, 0);
        sweep("R3 R12 reset sweep");

        // R1 offset port holds all 32 bits; data read of an unused offset
        bus_write(P_OFS, 32'h1234_5678);
        bus_read(P_OFS, d, v);
        chk(v && d == 32'h1234_5678, "R1 offset readback", d, 32'h1234_5678);
        bus_read(P_DATA, d, v);
        chk(v && d == 32'hFFFF_FFFF, "R12 undefined offset", d, 32'hFFFF_FFFF);
        // R1 other bus address: no response
        bus_read(10'h012, d, v);
        chk(v == 0, "R1 foreign address rvalid", 32'(v), 0);
        // R2 valid lasts one cycle
        @(negedge clk);
        chk(bus_rvalid_o == 0, "R2 rvalid single cycle", 32'(bus_rvalid_o), 0);

        // R4 R5 R8 R9 R10 R11 pattern sweeps over all defined offsets
        foreach (pats[p]) begin
            foreach (defs[j]) reg_write(defs[j], pats[p] ^ (32'(j) << 8));
            out_check("R9 R10 R11 pattern outputs");
            sweep("R4 R5 R8 R9 R10 R12 pattern sweep");
        end

        // R6 R7 directed sequence on configuration edges
        reg_write(32'h20, 32'h0000_0000);
        reg_write(32'h20, 32'h8000_0000);
        chk(ctl_enable_o == 1, "R6 enable rises", 32'(ctl_enable_o), 1);
        reg_check(32'h24, "R6 status31 cleared");
        reg_write(32'h44, 32'h0000_0001);
        reg_write(32'h40, 32'h0000_0000);
        out_check("R10 map follows bank bit0");
        reg_write(32'h20, 32'hC000_0000);
        reg_check(32'h24, "R7 status30 set");
        reg_write(32'h20, 32'h4000_0000);
        chk(ctl_enable_o == 0, "R6 enable falls", 32'(ctl_enable_o), 0);
        chk(bank_map_en_o == 0, "R10 unmapped when disabled", 32'(bank_map_en_o), 0);
        reg_check(32'h24, "R6 R7 status C0000000");
        reg_write(32'h20, 32'h4000_0000);
        reg_check(32'h24, "R6 unchanged bit keeps status");
        reg_write(32'h24, 32'h0000_0000);
        reg_check(32'h24, "R8 status ignores write");
        reg_write(32'h20, 32'h0000_0000);
        reg_check(32'h24, "R7 status30 cleared");

        // R11 interrupt edges, R2 write takes effect at the sampling edge
        reg_write(32'h98, 32'h0000_1000);
        chk(ecc_irq_o == 1, "R11 R2 irq rises", 32'(ecc_irq_o), 1);
        reg_write(32'h98, 32'h000F_0FFF);
        chk(ecc_irq_o == 0, "R11 irq falls on masked zero", 32'(ecc_irq_o), 0);
        reg_check(32'h98, "R11 ecc status masked");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule